// File: doc/BRIEF.md
# Paged Serial-Memory Transfer Sequencer

This block runs whole block writes and block reads to a serial memory device that sits on a two-wire bus. It does not drive the bus itself. It issues a stream of byte-level commands (start, repeated start, stop, send a byte, switch to receive, receive a byte) to a byte engine and consumes that engine's per-byte completion responses. A request carries a 7-bit device address, a start offset that is one or two bytes wide, a byte count and a direction. Write data arrives on a valid/ready input stream, and read data leaves on a valid/ready output stream.

Writes are cut into 8-byte pages. Each page is a separate START…STOP transaction that is re-addressed with the offset reached so far. When the start offset is unaligned, the first transaction carries only the bytes up to the next page boundary. A read addresses the device in write direction and sends the offset. It then issues a repeated start, addresses the device in read direction, switches the engine to receive and fetches the bytes one at a time. Acknowledge suppression is flagged on the final byte.

Any byte the engine reports as failed ends the request with a STOP and an error. An arbitration-lost indication that is present when a request is accepted is cleared, and the request is failed without touching the bus.

Back-pressure rules:
- An input byte moves only on a cycle where `in_valid` and `in_ready` are both high. `in_valid` must stay high until that happens.
- A byte offered on `out_valid` holds its value until `out_ready` takes it. The next receive is not started before then.
- A command is offered with `cmd_valid` and is consumed only on a cycle where `cmd_ready` is high.
- The engine sends exactly one `rsp_valid` pulse for each send-byte or receive-byte command. That pulse comes at least one cycle after the command is accepted.

Top module: `pgmem_seq`

## Requirements
- R1: Every transaction starts with command code 0 (START). Next comes code 1 (send byte) carrying the address byte, which is the device address in bits 7:1 and the direction bit in bit 0 (0 = write, 1 = read). The offset follows.
- R2: With `req_wide`=1 the offset goes out as two send-byte commands, bits 15:8 first and then bits 7:0. With `req_wide`=0 only bits 7:0 are sent.
- R3: A write whose offset is not a multiple of 8 first sends only the bytes up to the next multiple of 8, then code 5 (STOP).
- R4: The remaining write bytes go out in fresh transactions, each re-addressed with the updated offset. Each of these transactions ends with STOP after 8 data bytes or after the request's last byte.
- R5: When a response arrives with `rsp_ok`=0, the next command is STOP. The request then ends with `err`=1, and no other command is issued.
- R6: A read sends the address (bit 0 = 0) and the offset, then code 2 (repeated START), then the address with bit 0 = 1. It then sends code 3 (switch to receive, the dummy fetch that starts reception), one code 4 (receive byte) per requested byte, and finally STOP.
- R7: `cmd_nack` is 1 on the final receive-byte command only. Received bytes leave on the output stream in order and stay stable while back-pressured.
- R8: If `arb_lost` is high when a request is accepted, `arb_clr` pulses for one cycle. No command is issued, and the request ends with `err`=1.
- R9: `done` is high for exactly one cycle per request, and `err` is valid with it. A request of length 0 completes with no commands and `err`=0. After reset `req_ready`=1 and `done`, `cmd_valid` and `out_valid` are 0.
- R10: A write consumes exactly `req_len` bytes from the input stream, in order. Each one is carried by one send-byte command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle |
| req_rd | input | 1 | 1 = block read, 0 = block write |
| req_dev | input | 7 | Device address |
| req_off | input | 16 | Start offset |
| req_wide | input | 1 | 1 = two-byte offset |
| req_len | input | LEN_W | Byte count |
| arb_lost | input | 1 | Arbitration-lost indication from the engine |
| arb_clr | output | 1 | One-cycle clear of arbitration-lost |
| in_valid | input | 1 | Write byte offered |
| in_ready | output | 1 | Write byte taken |
| in_data | input | 8 | Write byte |
| out_valid | output | 1 | Read byte offered |
| out_ready | input | 1 | Read byte taken |
| out_data | output | 8 | Read byte |
| cmd_valid | output | 1 | Engine command offered |
| cmd_ready | input | 1 | Engine accepts command |
| cmd_op | output | 3 | Command code (0 START, 1 send, 2 repeated START, 3 switch to receive, 4 receive, 5 STOP) |
| cmd_byte | output | 8 | Byte for a send command |
| cmd_nack | output | 1 | Suppress acknowledge on this receive |
| rsp_valid | input | 1 | Engine finished a send or receive |
| rsp_ok | input | 1 | Byte completed and acknowledged |
| rsp_data | input | 8 | Received byte |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Request failed, valid with done |

## Verification
A wrong offset cursor shows up in the very next re-addressing. The offset bytes in the command stream are off, or the page STOP lands one byte early or late. Either shows on the first page boundary the request crosses. A wrong state after a failed response shows up within one cycle as a command other than STOP. An output holding register that loses a byte under back-pressure shows up as a missing or repeated value in the read stream. Sweeping every offset within two pages against several lengths and both offset widths exposes every boundary case of the page split.

// File: rtl/pgmem_pkg.sv
package pgmem_pkg;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_WR     = 3'd1,
    OP_RSTART = 3'd2,
    OP_RXON   = 3'd3,
    OP_RD     = 3'd4,
    OP_STOP   = 3'd5
  } seq_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_DEV, S_OFFH, S_OFFL, S_WDATA, S_RSTART,
    S_RXON, S_RD, S_WAIT, S_OUT, S_STOP, S_FIN
  } seq_st_e;

endpackage

// File: rtl/pgmem_cursor.sv
// Offset and remaining-length tracker with page-boundary detection.
module pgmem_cursor #(
  parameter int LEN_W      = 8,
  parameter int OFF_W      = 16,
  parameter int PAGE_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_off,
  input  logic [LEN_W-1:0] load_len,
  input  logic             step,
  output logic [OFF_W-1:0] off,
  output logic [LEN_W-1:0] remain,
  output logic             last,
  output logic             empty,
  output logic             page_end
);
  localparam int PG_W = $clog2(PAGE_BYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off    <= '0;
      remain <= '0;
    end else if (load) begin
      off    <= load_off;
      remain <= load_len;
    end else if (step) begin
      off    <= off + 1'b1;
      remain <= remain - 1'b1;
    end
  end

  assign empty = (remain == '0);
  assign last  = (remain == LEN_W'(1));

  // page_end: the byte at the current offset is the last one of its page
  generate
    if (PG_W == 0) begin : g_unit_page
      assign page_end = 1'b1;
    end else begin : g_page
      assign page_end = &off[PG_W-1:0];
    end
  endgenerate

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !empty);

  a_r4_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (off == $past(off) + 1'b1));

endmodule

// File: rtl/pgmem_rxhold.sv
// Single-entry holding register for received bytes on the output stream.
module pgmem_rxhold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] cap_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (capture) begin
      out_valid <= 1'b1;
      out_data  <= cap_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: rtl/pgmem_seq.sv
module pgmem_seq
  import pgmem_pkg::*;
#(
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rd,
  input  logic [6:0]       req_dev,
  input  logic [15:0]      req_off,
  input  logic             req_wide,
  input  logic [LEN_W-1:0] req_len,
  input  logic             arb_lost,
  output logic             arb_clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             rsp_valid,
  input  logic             rsp_ok,
  input  logic [7:0]       rsp_data,
  output logic             done,
  output logic             err
);
  localparam int OFF_W = 16;

  seq_st_e st_q, nxt_q;
  seq_op_e op;
  logic [6:0] dev_q;
  logic       rd_q, wide_q, phase_q, err_q, arb_q;
  logic       fire, load, step, capture;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] remain;
  logic       last, empty, page_end;

  pgmem_cursor #(.LEN_W(LEN_W), .OFF_W(OFF_W), .PAGE_BYTES(PAGE_BYTES)) u_cursor (
    .clk(clk), .rst_n(rst_n), .load(load), .load_off(req_off), .load_len(req_len),
    .step(step), .off(off), .remain(remain), .last(last), .empty(empty),
    .page_end(page_end)
  );

  pgmem_rxhold #(.W(8)) u_rxhold (
    .clk(clk), .rst_n(rst_n), .capture(capture), .cap_data(rsp_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // command presented for the current state
  always_comb begin
    op        = OP_START;
    cmd_valid = 1'b1;
    cmd_byte  = 8'h00;
    unique case (st_q)
      S_START:  op = OP_START;
      S_DEV:    begin op = OP_WR; cmd_byte = {dev_q, phase_q}; end
      S_OFFH:   begin op = OP_WR; cmd_byte = off[15:8]; end
      S_OFFL:   begin op = OP_WR; cmd_byte = off[7:0]; end
      S_WDATA:  begin op = OP_WR; cmd_byte = in_data; cmd_valid = in_valid; end
      S_RSTART: op = OP_RSTART;
      S_RXON:   op = OP_RXON;
      S_RD:     op = OP_RD;
      S_STOP:   op = OP_STOP;
      default:  cmd_valid = 1'b0;
    endcase
  end

  assign cmd_op    = op;
  assign cmd_nack  = (st_q == S_RD) && last;
  assign fire      = cmd_valid && cmd_ready;
  assign in_ready  = (st_q == S_WDATA) && cmd_ready;
  assign req_ready = (st_q == S_IDLE);
  assign load      = req_ready && req_valid;
  assign step      = fire && (st_q == S_WDATA || st_q == S_RD);
  assign capture   = (st_q == S_WAIT) && rsp_valid && rsp_ok && (nxt_q == S_OUT);
  assign done      = (st_q == S_FIN);
  assign err       = done && err_q;
  assign arb_clr   = arb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      nxt_q   <= S_IDLE;
      dev_q   <= '0;
      rd_q    <= 1'b0;
      wide_q  <= 1'b0;
      phase_q <= 1'b0;
      err_q   <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      arb_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (req_valid) begin
          dev_q   <= req_dev;
          rd_q    <= req_rd;
          wide_q  <= req_wide;
          phase_q <= 1'b0;
          err_q   <= arb_lost;
          arb_q   <= arb_lost;
          if (arb_lost || req_len == '0) st_q <= S_FIN;
          else                           st_q <= S_START;
        end
        S_START:  if (fire) st_q <= S_DEV;
        S_DEV:    if (fire) begin
          st_q  <= S_WAIT;
          nxt_q <= phase_q ? S_RXON : (wide_q ? S_OFFH : S_OFFL);
        end
        S_OFFH:   if (fire) begin st_q <= S_WAIT; nxt_q <= S_OFFL; end
        S_OFFL:   if (fire) begin
          st_q  <= S_WAIT;
          nxt_q <= rd_q ? S_RSTART : S_WDATA;
        end
        S_WDATA:  if (fire) begin
          st_q  <= S_WAIT;
          nxt_q <= (last || page_end) ? S_STOP : S_WDATA;
        end
        S_RSTART: if (fire) begin st_q <= S_DEV; phase_q <= 1'b1; end
        S_RXON:   if (fire) st_q <= S_RD;
        S_RD:     if (fire) begin st_q <= S_WAIT; nxt_q <= S_OUT; end
        S_WAIT:   if (rsp_valid) begin
          if (rsp_ok) st_q <= nxt_q;
          else begin
            err_q <= 1'b1;
            st_q  <= S_STOP;
          end
        end
        S_OUT:    if (!out_valid) st_q <= empty ? S_STOP : S_RD;
        S_STOP:   if (fire) st_q <= (err_q || empty) ? S_FIN : S_START;
        S_FIN:    st_q <= S_IDLE;
        default:  st_q <= S_IDLE;
      endcase
    end
  end

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WAIT && rsp_valid && !rsp_ok) |=> (cmd_valid && cmd_op == 3'd5));

  a_r8_arb_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && arb_lost) |=> (arb_clr && !cmd_valid && err));

  a_r1_addr_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cmd_op == 3'd0) |=> (cmd_valid && cmd_op == 3'd1 && cmd_byte[7:1] == dev_q));

endmodule

// File: tb/pgmem_seq_test.sv
module pgmem_seq_test;
  localparam int LEN_W = 8;
  localparam int C_START = 0, C_WR = 1, C_RSTART = 2, C_RXON = 3, C_RD = 4, C_STOP = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_rd = 0, req_wide = 0, arb_lost = 0;
  logic [6:0] req_dev = 0;
  logic [15:0] req_off = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic wr_en = 0, tb_clr = 0;
  logic req_ready, arb_clr, in_ready, out_valid, cmd_valid, cmd_nack, done, err;
  logic [7:0] out_data, cmd_byte, in_data;
  logic [2:0] cmd_op;
  logic rsp_valid = 0, rsp_ok = 0;
  logic [7:0] rsp_data = 0;
  logic cmd_ready, out_ready, in_valid;

  int cyc = 0, checks = 0, fails = 0;
  int pend = 0, resp_n = 0, rdn = 0, widx = 0, fail_at = 0;
  logic pend_ok = 1;
  logic [7:0] pend_data = 0;
  logic arb_seen = 0;
  int log_q[$];
  int outb_q[$];
  int exp_q[$];

  always #10 clk = ~clk;

  assign cmd_ready = (cyc % 3) != 0;
  assign out_ready = (cyc % 4) != 1;
  assign in_valid  = wr_en;
  assign in_data   = 8'h30 + widx[7:0];

  pgmem_seq #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rd(req_rd), .req_dev(req_dev), .req_off(req_off), .req_wide(req_wide),
    .req_len(req_len), .arb_lost(arb_lost), .arb_clr(arb_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_ok(rsp_ok), .rsp_data(rsp_data), .done(done), .err(err)
  );

  // byte-engine and stream model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    rsp_valid <= 1'b0;
    if (tb_clr) begin
      pend <= 0; resp_n <= 0; rdn <= 0; widx <= 0; arb_seen <= 1'b0;
      log_q.delete(); outb_q.delete();
    end else begin
      if (arb_clr) arb_seen <= 1'b1;
      if (out_valid && out_ready) outb_q.push_back(int'(out_data));
      if (in_valid && in_ready) widx <= widx + 1;
      if (pend != 0) begin
        pend <= pend - 1;
        if (pend == 1) begin
          rsp_valid <= 1'b1; rsp_ok <= pend_ok; rsp_data <= pend_data;
        end
      end
      if (cmd_valid && cmd_ready) begin
        log_q.push_back(int'(cmd_op) * 512 +
                        ((int'(cmd_op) == C_RD && cmd_nack) ? 256 : 0) +
                        ((int'(cmd_op) == C_WR) ? int'(cmd_byte) : 0));
        if (int'(cmd_op) == C_WR || int'(cmd_op) == C_RD) begin
          pend      <= 2;
          pend_ok   <= (resp_n + 1) != fail_at;
          resp_n    <= resp_n + 1;
          pend_data <= 8'hC0 + rdn[7:0];
          if (int'(cmd_op) == C_RD) rdn <= rdn + 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      $display("FAIL R9 watchdog expired: actual hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks + 1, fails + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push_wr(input int b);
    exp_q.push_back(C_WR * 512 + (b & 255));
  endtask

  // one request, expected command stream computed from the requirements
  task automatic run_req(input bit rd, input int dev, input int off, input bit wide,
                         input int len, input int fail_n, input bit arb, input string tag);
    int o, rem, k, nresp, cut, mism, dcyc;
    bit exp_err;
    exp_q.delete();
    o = off; rem = len; k = 0;
    if (!arb && len != 0) begin
      if (!rd) begin
        while (rem > 0) begin
          exp_q.push_back(C_START * 512);
          push_wr(dev * 2);
          if (wide) push_wr((o >> 8) & 255);
          push_wr(o & 255);
          do begin
            push_wr(8'h30 + k); k++; o = (o + 1) & 16'hFFFF; rem--;
          end while (rem > 0 && (o % 8) != 0);
          exp_q.push_back(C_STOP * 512);
        end
      end else begin
        exp_q.push_back(C_START * 512);
        push_wr(dev * 2);
        if (wide) push_wr((o >> 8) & 255);
        push_wr(o & 255);
        exp_q.push_back(C_RSTART * 512);
        push_wr(dev * 2 + 1);
        exp_q.push_back(C_RXON * 512);
        for (int i = 0; i < len; i++) exp_q.push_back(C_RD * 512 + ((i == len - 1) ? 256 : 0));
        exp_q.push_back(C_STOP * 512);
      end
    end
    exp_err = arb;
    if (fail_n > 0) begin
      nresp = 0; cut = -1;
      for (int i = 0; i < exp_q.size(); i++) begin
        if ((exp_q[i] / 512) == C_WR || (exp_q[i] / 512) == C_RD) begin
          nresp++;
          if (nresp == fail_n && cut < 0) cut = i;
        end
      end
      if (cut >= 0) begin
        while (exp_q.size() > cut + 1) void'(exp_q.pop_back());
        exp_q.push_back(C_STOP * 512);
        exp_err = 1;
      end
    end
    @(negedge clk);
    tb_clr = 1; fail_at = fail_n;
    @(negedge clk);
    tb_clr = 0;
    req_rd = rd; req_dev = 7'(dev); req_off = 16'(off); req_wide = wide;
    req_len = LEN_W'(len); arb_lost = arb; wr_en = !rd; req_valid = 1;
    @(posedge clk);
    dcyc = 0;
    forever begin
      @(negedge clk);
      req_valid = 0; arb_lost = 0;
      if (done) break;
      dcyc++;
      if (dcyc > 20000) break;
    end
    check(done == 1'b1 && err == exp_err, {tag, " R9 done/err"}, int'(err), int'(exp_err));
    @(negedge clk);
    check(done == 1'b0, "R9 done one cycle", int'(done), 0);
    wr_en = 0;
    mism = -1;
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      if (mism < 0 && log_q[i] != exp_q[i]) mism = i;
    if (mism >= 0)
      check(0, {tag, " command stream"}, log_q[mism], exp_q[mism]);
    else
      check(log_q.size() == exp_q.size(), {tag, " command count"}, log_q.size(), exp_q.size());
    if (arb) check(arb_seen == 1'b1, "R8 arb_clr pulse", int'(arb_seen), 1);
    if (!rd && !arb && fail_n == 0)
      check(widx == len, "R10 input bytes consumed", widx, len);
    if (rd && !arb && fail_n == 0) begin
      check(outb_q.size() == len, "R7 read byte count", outb_q.size(), len);
      for (int i = 0; i < outb_q.size() && i < len; i++)
        check(outb_q[i] == (8'hC0 + i), "R7 read byte order", outb_q[i], 8'hC0 + i);
    end
  endtask

  initial begin
    int lens[5] = '{1, 3, 8, 9, 17};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1'b1 && done == 1'b0 && cmd_valid == 1'b0 && out_valid == 1'b0,
          "R9 reset state", int'({req_ready, done, cmd_valid, out_valid}), 8);
    // page-split sweep: R1 R2 R3 R4 R10
    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 12; o++)
        for (int l = 0; l < 5; l++)
          run_req(0, 7'h50 + (o % 4), (w != 0) ? (16'h2A00 + o) : o, w != 0,
                  lens[l], 0, 0, "R1 R2 R3 R4 write");
    run_req(0, 7'h51, 8'hFC, 0, 9, 0, 0, "R2 R4 narrow wrap write");
    run_req(0, 7'h52, 16'h01FD, 1, 6, 0, 0, "R2 R4 wide carry write");
    // reads: R1 R2 R6 R7
    for (int w = 0; w < 2; w++)
      for (int l = 1; l <= 4; l++)
        run_req(1, 7'h6A, (w != 0) ? 16'h1234 : 16'h0077, w != 0, l, 0, 0, "R6 R7 read");
    // failures: R5
    run_req(0, 7'h50, 16'h0105, 1, 10, 2, 0, "R5 fail on offset");
    run_req(0, 7'h50, 5, 0, 12, 7, 0, "R5 fail in second page");
    run_req(1, 7'h50, 9, 0, 4, 6, 0, "R5 fail on receive");
    run_req(1, 7'h50, 9, 0, 3, 1, 0, "R5 fail on address");
    // arbitration lost and zero length
    run_req(0, 7'h50, 3, 0, 5, 0, 1, "R8 arb lost write");
    run_req(1, 7'h50, 3, 1, 2, 0, 1, "R8 arb lost read");
    run_req(0, 7'h50, 3, 0, 0, 0, 0, "R9 zero length");
    run_req(0, 7'h53, 0, 0, 2, 0, 0, "R1 after corner cases");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule